// File: doc/BRIEF.md
# Two-Wire DAC Command Decoder

This block sits behind a two-wire serial slave bit engine and works at byte level. The bit engine reports bus START and STOP conditions, hands over every received byte with a one-cycle valid strobe, and asks for the next byte to shift out during a read. The decoder decides whether each received byte is acknowledged. It also keeps the 10-bit code that drives a voltage DAC, and raises one-cycle request pulses towards a one-time-programmable (OTP) memory manager.

A write transaction carries one of three operations, chosen by the top three bits of the first data byte: a plain DAC load, an OTP write that also loads the DAC, or an acquire that reloads the DAC from the most recently stored OTP word. Nothing is updated until the frame for that operation is complete. A read transaction returns a two-byte frame that carries the OTP programming status and the current DAC code.

The received-byte and transmit-byte paths are strobed streams. The decoder accepts a byte on every cycle in which `rx_valid` is high and never applies back-pressure, so the bit engine needs no ready signal. Every `tx_req` seen during a read is answered with `tx_valid` on the following cycle. Ack decisions and both transmit outputs appear one clock after the strobe that caused them.

Top module: `dac_cmd_decoder`

## Requirements
- R1: The slave address is the 7-bit value {1,1,1,0,1,strap_a1,strap_a0} (74h to 77h). An address byte whose upper seven bits match is acknowledged. A mismatching address byte is not acknowledged, and every later byte is not acknowledged either until the next START.
- R2: Bit 0 of the address byte selects the direction: 1 starts a read frame and 0 starts a write frame.
- R3: In a write, each data byte gets `ack_valid` with `ack_assert`=1 one cycle after its `rx_valid`. When the first byte's bits 7:5 are neither 010 nor 001, the frame is a DAC load. The new code is {first[1:0], second[7:0]}, and `dac_code` takes it one cycle after the second byte and never earlier.
- R4: When the first byte's bits 7:5 equal 010, the frame is an OTP write. One cycle after the second byte, `otp_wr_req` pulses for one cycle with `otp_wr_data` = {first[1:0], second[7:0]}, and `dac_code` takes the same value.
- R5: When the first byte's bits 7:5 equal 001, the byte is an acquire command and its bits 4:0 are ignored. On the STOP that follows, `acq_req` pulses for one cycle and `dac_code` loads `otp_value`.
- R6: A STOP or repeated START before a frame is complete changes neither `dac_code` nor the request outputs. A repeated START after an acquire byte cancels the acquire.
- R7: A read answers `tx_req` one cycle later with `tx_valid`. The first byte is {otp_status[3:0], 2'b00, dac_code[9:8]}, the second is dac_code[7:0], and any further byte is 00h.
- R8: Bytes that arrive after a complete frame and before STOP are acknowledged and have no effect on `dac_code` or the requests.
- R9: After reset `dac_code` equals RESET_CODE (default 512, mid-scale), and `ack_valid`, `otp_wr_req`, `acq_req` and `tx_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strap_a0 | input | 1 | Address bit 0 strap |
| strap_a1 | input | 1 | Address bit 1 strap (tied high on the narrow package) |
| bus_start | input | 1 | START or repeated START seen, one-cycle pulse |
| bus_stop | input | 1 | STOP seen, one-cycle pulse |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |
| tx_req | input | 1 | Bit engine asks for the next read byte |
| otp_status | input | 4 | OTP programming status from the OTP manager |
| otp_value | input | 10 | Most recently written OTP word |
| ack_valid | output | 1 | Ack decision for the byte of the previous cycle |
| ack_assert | output | 1 | 1 = acknowledge, 0 = leave SDA released |
| tx_valid | output | 1 | Read byte available |
| tx_data | output | 8 | Read byte |
| dac_code | output | 10 | DAC register |
| otp_wr_req | output | 1 | One-cycle OTP write request |
| otp_wr_data | output | 10 | Code to program into OTP |
| acq_req | output | 1 | One-cycle acquire request |

## Verification
On every cycle the assertions check that an ack decision only ever follows a received byte and that a mismatching address is refused. They also check that the DAC register moves only on a completed second byte or on a STOP, that an OTP write mirrors its code into the DAC, that an acquire loads the OTP word, that the two requests never coincide, and that read bytes only answer requests. Only the bench scenarios can show which code a given byte pair yields, how the operation is picked by the selector bits, and that aborted frames and cancelled acquires leave the register alone. The same holds for the exact read frame contents and for the address set by each strap combination.

// File: rtl/dcd_pkg.sv
package dcd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_W0, ST_W1, ST_ACQ, ST_DONE, ST_READ
  } dcd_state_e;

  typedef enum logic [1:0] {OP_DAC, OP_OTP, OP_ACQ} dcd_op_e;

  localparam logic [2:0] SEL_OTP = 3'b010;
  localparam logic [2:0] SEL_ACQ = 3'b001;

  function automatic dcd_op_e classify(input logic [2:0] sel);
    if (sel == SEL_OTP)      return OP_OTP;
    else if (sel == SEL_ACQ) return OP_ACQ;
    else                     return OP_DAC;
  endfunction
endpackage

// File: rtl/dcd_addr_match.sv
module dcd_addr_match #(
  parameter int BYTE_W  = 8,
  parameter int STRAP_W = 2,
  parameter logic [BYTE_W-STRAP_W-2:0] FIXED = 5'b11101
) (
  input  logic [BYTE_W-1:0]  byte_in,
  input  logic [STRAP_W-1:0] straps,
  output logic               hit,
  output logic               is_read
);
  localparam int ADDR_W = BYTE_W - 1;
  logic [ADDR_W-1:0] own_addr;

  assign own_addr = {FIXED, straps};
  assign hit      = (byte_in[BYTE_W-1:1] == own_addr);
  assign is_read  = byte_in[0];
endmodule

// File: rtl/dcd_frame_fsm.sv
module dcd_frame_fsm
  import dcd_pkg::*;
#(
  parameter int CODE_W = 10,
  parameter int BYTE_W = 8,
  parameter logic [CODE_W-1:0] RESET_CODE = 10'd512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_start,
  input  logic              bus_stop,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_data,
  input  logic              addr_hit,
  input  logic              addr_read,
  input  logic [CODE_W-1:0] otp_value,
  output logic              ack_valid,
  output logic              ack_assert,
  output logic [CODE_W-1:0] dac_code,
  output logic              otp_wr_req,
  output logic [CODE_W-1:0] otp_wr_data,
  output logic              acq_req,
  output logic              rd_active
);
  localparam int HI_W = CODE_W - BYTE_W;

  dcd_state_e        st;
  dcd_op_e           op;
  logic [HI_W-1:0]   hi_bits;
  logic [CODE_W-1:0] new_code;

  assign new_code  = {hi_bits, rx_data};
  assign rd_active = (st == ST_READ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= ST_IDLE;
      op          <= OP_DAC;
      hi_bits     <= '0;
      dac_code    <= RESET_CODE;
      otp_wr_req  <= 1'b0;
      otp_wr_data <= '0;
      acq_req     <= 1'b0;
      ack_valid   <= 1'b0;
      ack_assert  <= 1'b0;
    end else begin
      ack_valid  <= 1'b0;
      otp_wr_req <= 1'b0;
      acq_req    <= 1'b0;
      if (bus_stop) begin
        if (st == ST_ACQ) begin
          acq_req  <= 1'b1;
          dac_code <= otp_value;
        end
        st <= ST_IDLE;
      end else if (bus_start) begin
        st <= ST_ADDR;
      end else if (rx_valid) begin
        ack_valid <= 1'b1;
        case (st)
          ST_ADDR: begin
            ack_assert <= addr_hit;
            if (!addr_hit)      st <= ST_IDLE;
            else if (addr_read) st <= ST_READ;
            else                st <= ST_W0;
          end
          ST_W0: begin
            ack_assert <= 1'b1;
            if (classify(rx_data[BYTE_W-1:BYTE_W-3]) == OP_ACQ) begin
              st <= ST_ACQ;
            end else begin
              op      <= classify(rx_data[BYTE_W-1:BYTE_W-3]);
              hi_bits <= rx_data[HI_W-1:0];
              st      <= ST_W1;
            end
          end
          ST_W1: begin
            ack_assert <= 1'b1;
            dac_code   <= new_code;
            if (op == OP_OTP) begin
              otp_wr_req  <= 1'b1;
              otp_wr_data <= new_code;
            end
            st <= ST_DONE;
          end
          ST_ACQ, ST_DONE: ack_assert <= 1'b1;
          default:         ack_assert <= 1'b0;
        endcase
      end
    end
  end

  assert_ack_follows_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |-> $past(rx_valid));

  assert_foreign_addr_nack_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !bus_start && !bus_stop && st == ST_ADDR && !addr_hit)
      |=> (ack_valid && !ack_assert));

  assert_dac_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_code != $past(dac_code)) |-> ($past(bus_stop) || ($past(rx_valid) && $past(st) == ST_W1)));

  assert_otp_mirror_R4: assert property (@(posedge clk) disable iff (!rst_n)
    otp_wr_req |-> (dac_code == otp_wr_data));

  assert_acq_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    acq_req |-> (dac_code == $past(otp_value)));

  assert_single_request_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({otp_wr_req, acq_req}));
endmodule

// File: rtl/dcd_read_frame.sv
module dcd_read_frame #(
  parameter int CODE_W = 10,
  parameter int STAT_W = 4,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_active,
  input  logic              bus_start,
  input  logic              bus_stop,
  input  logic              tx_req,
  input  logic [STAT_W-1:0] otp_status,
  input  logic [CODE_W-1:0] dac_code,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_data
);
  localparam int HI_W  = CODE_W - BYTE_W;
  localparam int PAD_W = BYTE_W - STAT_W - HI_W;

  logic [1:0]        idx;
  logic [BYTE_W-1:0] ms_byte;
  logic [BYTE_W-1:0] ls_byte;

  assign ms_byte = {otp_status, {PAD_W{1'b0}}, dac_code[CODE_W-1:BYTE_W]};
  assign ls_byte = dac_code[BYTE_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx      <= '0;
      tx_valid <= 1'b0;
      tx_data  <= '0;
    end else begin
      tx_valid <= 1'b0;
      if (bus_start || bus_stop) begin
        idx <= '0;
      end else if (tx_req && rd_active) begin
        tx_valid <= 1'b1;
        case (idx)
          2'd0:    tx_data <= ms_byte;
          2'd1:    tx_data <= ls_byte;
          default: tx_data <= '0;
        endcase
        if (idx != 2'd2) idx <= idx + 2'd1;
      end
    end
  end

  assert_tx_answers_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> $past(tx_req && rd_active));
endmodule

// File: rtl/dac_cmd_decoder.sv
module dac_cmd_decoder #(
  parameter int CODE_W = 10,
  parameter int STAT_W = 4,
  parameter int BYTE_W = 8,
  parameter logic [CODE_W-1:0] RESET_CODE = 10'd512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_a0,
  input  logic              strap_a1,
  input  logic              bus_start,
  input  logic              bus_stop,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_data,
  input  logic              tx_req,
  input  logic [STAT_W-1:0] otp_status,
  input  logic [CODE_W-1:0] otp_value,
  output logic              ack_valid,
  output logic              ack_assert,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_data,
  output logic [CODE_W-1:0] dac_code,
  output logic              otp_wr_req,
  output logic [CODE_W-1:0] otp_wr_data,
  output logic              acq_req
);
  logic addr_hit;
  logic addr_read;
  logic rd_active;

  dcd_addr_match #(.BYTE_W(BYTE_W), .STRAP_W(2)) u_match (
    .byte_in (rx_data),
    .straps  ({strap_a1, strap_a0}),
    .hit     (addr_hit),
    .is_read (addr_read)
  );

  dcd_frame_fsm #(.CODE_W(CODE_W), .BYTE_W(BYTE_W), .RESET_CODE(RESET_CODE)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_start   (bus_start),
    .bus_stop    (bus_stop),
    .rx_valid    (rx_valid),
    .rx_data     (rx_data),
    .addr_hit    (addr_hit),
    .addr_read   (addr_read),
    .otp_value   (otp_value),
    .ack_valid   (ack_valid),
    .ack_assert  (ack_assert),
    .dac_code    (dac_code),
    .otp_wr_req  (otp_wr_req),
    .otp_wr_data (otp_wr_data),
    .acq_req     (acq_req),
    .rd_active   (rd_active)
  );

  dcd_read_frame #(.CODE_W(CODE_W), .STAT_W(STAT_W), .BYTE_W(BYTE_W)) u_rd (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_active  (rd_active),
    .bus_start  (bus_start),
    .bus_stop   (bus_stop),
    .tx_req     (tx_req),
    .otp_status (otp_status),
    .dac_code   (dac_code),
    .tx_valid   (tx_valid),
    .tx_data    (tx_data)
  );
endmodule

// File: tb/dac_cmd_decoder_tb.sv
module dac_cmd_decoder_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       strap_a0 = 1'b0, strap_a1 = 1'b1;
  logic       bus_start = 1'b0, bus_stop = 1'b0;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_data = '0;
  logic       tx_req = 1'b0;
  logic [3:0] otp_status = 4'b0111;
  logic [9:0] otp_value = 10'h2AB;
  logic       ack_valid, ack_assert, tx_valid, otp_wr_req, acq_req;
  logic [7:0] tx_data;
  logic [9:0] dac_code, otp_wr_data;

  int checks = 0;
  int fails = 0;
  int n_otp = 0;
  int n_acq = 0;
  logic [9:0] last_otp = '0;

  always #2 clk = ~clk;

  dac_cmd_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .strap_a0(strap_a0), .strap_a1(strap_a1),
    .bus_start(bus_start), .bus_stop(bus_stop), .rx_valid(rx_valid), .rx_data(rx_data),
    .tx_req(tx_req), .otp_status(otp_status), .otp_value(otp_value),
    .ack_valid(ack_valid), .ack_assert(ack_assert), .tx_valid(tx_valid), .tx_data(tx_data),
    .dac_code(dac_code), .otp_wr_req(otp_wr_req), .otp_wr_data(otp_wr_data), .acq_req(acq_req)
  );

  always @(posedge clk) begin
    if (rst_n && otp_wr_req) begin
      n_otp <= n_otp + 1;
      last_otp <= otp_wr_data;
    end
    if (rst_n && acq_req) n_acq <= n_acq + 1;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) bus_start = 1'b1;
    @(negedge clk) bus_start = 1'b0;
  endtask

  task automatic pulse_stop();
    @(negedge clk) bus_stop = 1'b1;
    @(negedge clk) bus_stop = 1'b0;
    @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b, input logic exp_ack, input string tag);
    @(negedge clk) begin rx_valid = 1'b1; rx_data = b; end
    @(negedge clk) rx_valid = 1'b0;
    check(tag, {ack_valid, ack_assert}, {1'b1, exp_ack});
  endtask

  task automatic read_byte(input logic [7:0] exp, input string tag);
    @(negedge clk) tx_req = 1'b1;
    @(negedge clk) tx_req = 1'b0;
    check(tag, {tx_valid, tx_data}, {1'b1, exp});
  endtask

  // address byte, first data byte, second data byte, expected DAC code
  localparam logic [33:0] VEC [0:7] = '{
    {8'hEC, 8'h03, 8'hFF, 10'h3FF},
    {8'hEC, 8'h00, 8'h00, 10'h000},
    {8'hEC, 8'h01, 8'h55, 10'h155},
    {8'hEC, 8'hE2, 8'h34, 10'h234},
    {8'hEC, 8'h42, 8'h7A, 10'h27A},
    {8'hEC, 8'h1D, 8'h0F, 10'h10F},
    {8'hEC, 8'h80, 8'h81, 10'h081},
    {8'hEC, 8'h43, 8'h00, 10'h300}
  };

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int base_otp, base_acq;
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9 reset code", dac_code, 10'd512);
    check("R9 reset strobes", {ack_valid, otp_wr_req, acq_req, tx_valid}, 4'b0);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);

    // R3/R4 table walk
    for (int i = 0; i < 8; i++) begin
      base_otp = n_otp;
      pulse_start();
      send_byte(VEC[i][33:26], 1'b1, "R1 addr ack");
      send_byte(VEC[i][25:18], 1'b1, "R3 first byte ack");
      check("R3 no load before second byte", dac_code,
            (i == 0) ? 10'd512 : VEC[i-1][9:0]);
      send_byte(VEC[i][17:10], 1'b1, "R3 second byte ack");
      check("R3 code loaded", dac_code, VEC[i][9:0]);
      pulse_stop();
      check("R4 otp pulse count", n_otp - base_otp, (VEC[i][25:23] == 3'b010) ? 1 : 0);
      if (VEC[i][25:23] == 3'b010) check("R4 otp data", last_otp, VEC[i][9:0]);
    end

    // R5 acquire, low bits ignored
    base_acq = n_acq;
    pulse_start();
    send_byte(8'hEC, 1'b1, "R1 addr ack");
    send_byte(8'h3F, 1'b1, "R5 acquire byte ack");
    check("R5 no load before stop", dac_code, 10'h300);
    pulse_stop();
    check("R5 acquire pulse", n_acq - base_acq, 1);
    check("R5 acquire load", dac_code, 10'h2AB);

    // R6 acquire cancelled by repeated start
    otp_value = 10'h155;
    base_acq = n_acq;
    pulse_start();
    send_byte(8'hEC, 1'b1, "R1 addr ack");
    send_byte(8'h20, 1'b1, "R5 acquire byte ack");
    pulse_start();
    send_byte(8'hEC, 1'b1, "R1 addr ack after restart");
    pulse_stop();
    check("R6 cancelled acquire pulse", n_acq - base_acq, 0);
    check("R6 cancelled acquire code", dac_code, 10'h2AB);

    // R6 aborted DAC / OTP frames
    base_otp = n_otp;
    pulse_start();
    send_byte(8'hEC, 1'b1, "R1 addr ack");
    send_byte(8'h01, 1'b1, "R3 first byte ack");
    pulse_stop();
    check("R6 stop abort", dac_code, 10'h2AB);
    pulse_start();
    send_byte(8'hEC, 1'b1, "R1 addr ack");
    send_byte(8'h42, 1'b1, "R4 first byte ack");
    pulse_start();
    send_byte(8'hEC, 1'b1, "R1 addr ack after restart");
    pulse_stop();
    check("R6 restart abort code", dac_code, 10'h2AB);
    check("R6 restart abort otp", n_otp - base_otp, 0);

    // R7/R2 read frame
    pulse_start();
    send_byte(8'hED, 1'b1, "R2 read addr ack");
    read_byte(8'h72, "R7 MS byte");
    read_byte(8'hAB, "R7 LS byte");
    read_byte(8'h00, "R7 extra byte");
    pulse_stop();
    check("R2 read leaves code", dac_code, 10'h2AB);

    // R1 mismatch address
    pulse_start();
    send_byte(8'hE8, 1'b0, "R1 foreign addr nack");
    send_byte(8'h03, 1'b0, "R1 later byte nack");
    send_byte(8'hFF, 1'b0, "R1 later byte nack");
    pulse_stop();
    check("R1 foreign write ignored", dac_code, 10'h2AB);

    // R1 other strap combination
    strap_a1 = 1'b0; strap_a0 = 1'b1;
    pulse_start();
    send_byte(8'hEC, 1'b0, "R1 old addr nack");
    pulse_stop();
    pulse_start();
    send_byte(8'hEA, 1'b1, "R1 strap addr ack");
    send_byte(8'h01, 1'b1, "R3 first byte ack");
    send_byte(8'h23, 1'b1, "R3 second byte ack");
    pulse_stop();
    check("R1 strap write", dac_code, 10'h123);

    // R8 bytes after complete frame
    base_otp = n_otp;
    pulse_start();
    send_byte(8'hEA, 1'b1, "R1 addr ack");
    send_byte(8'h02, 1'b1, "R3 first byte ack");
    send_byte(8'h11, 1'b1, "R3 second byte ack");
    send_byte(8'h55, 1'b1, "R8 extra ack");
    send_byte(8'h43, 1'b1, "R8 extra ack");
    check("R8 extra ignored", dac_code, 10'h211);
    pulse_stop();
    check("R8 extra code", dac_code, 10'h211);
    check("R8 extra no request", n_otp - base_otp, 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule